// File: doc/BRIEF.md
# Down-Counting Timer with Watchdog Lock and Output Stage

This block is a free-running down-counter that reloads itself from a software-programmed reload value. Each time the count reaches zero, it produces a one-cycle end-of-count pulse. That pulse drives three things:

- an output-pin stage, which either toggles the pin or copies a software-held level onto it;
- a system reset request, issued only when watchdog mode is active;
- two interrupt source selectors, one for the top-level line and one for channel A0.

Software reaches the registers through a plain byte-wide write/read port. The register map is:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | wait control |
| 2 | interrupt select |
| 3 | reload value, low byte |
| 4 | reload value, high byte |
| 5 | reload command (write-only trigger) |

Watchdog mode is entered by clearing an active-low enable bit. Once that bit is cleared, software cannot set it again until the next reset. A hardware strap input can also force watchdog mode. While watchdog mode is active, software must write the reload command before the count expires, or the block raises a one-cycle reset request.

All register access is single-cycle and is always accepted. There is no back-pressure, so the port carries no valid/ready pair.

Top module: `tmr_wdog`

## Requirements
- R1: After reset the registers read as follows: control reads 0x02 (write-out bit 1 is set, all other bits are 0), wait control reads 0x7F, interrupt select reads 0x06, and the reload bytes read the reset reload value. `tmr_oe` and `tmr_pin` are both 0.
- R2: The counter decrements once per clock. While the count is zero, `eoc` is high for exactly one cycle, and the next edge reloads the counter. The distance between end-of-count pulses is therefore reload+1 cycles.
- R3: Writing any value to address 5 loads the counter from the reload register at that clock edge. The next end of count then arrives reload+1 cycles after the write.
- R4: With control bit 2 (output mode) equal to 0 and control bit 0 (output enable) equal to 1, `tmr_pin` inverts at the clock edge that ends each end-of-count cycle.
- R5: With output mode equal to 1 and output enable equal to 1, `tmr_pin` takes the value of control bit 1 (write-out) at each end of count. Between ends of count the pin holds its level.
- R6: With output enable equal to 0, `tmr_oe` is 0 and the pin level does not change on an end of count.
- R7: Wait control bit 6 is the active-low watchdog enable. Writing 0 to it enters watchdog mode. Any later write of 1 to it is ignored, and the bit still reads 0.
- R8: In watchdog mode, `sys_rst_req` is high exactly in the end-of-count cycle. Outside watchdog mode it stays 0.
- R9: `hw_wdog_strap`=1 forces watchdog mode whatever the value of wait control bit 6.
- R10: Interrupt select bit 2 chooses the source of `tl_irq`: 0 selects the end of count, and 1 selects `nmi_in`.
- R11: Interrupt select bit 1 chooses the source of `a0_irq`: 0 selects the end of count, and 1 selects `ext_irq_in`.
- R12: Control bit 3 (input-section enable) is a plain read/write bit that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_addr | input | 3 | register address for read and write |
| reg_wr | input | 1 | write strobe |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data of the addressed register (combinational) |
| hw_wdog_strap | input | 1 | strap that forces watchdog mode |
| nmi_in | input | 1 | non-maskable interrupt source |
| ext_irq_in | input | 1 | external interrupt pin source |
| eoc | output | 1 | end-of-count pulse |
| tmr_pin | output | 1 | output pin level |
| tmr_oe | output | 1 | output pin drive enable |
| sys_rst_req | output | 1 | watchdog reset request |
| tl_irq | output | 1 | top-level interrupt source |
| a0_irq | output | 1 | channel A0 interrupt source |

## Verification
The bench builds the block with a 16-bit counter and a reset reload value of 20. This makes the first end of count arrive within a couple of dozen cycles, so the default period can be measured directly. The bench then programs short reload values (5, 3 and 0). These bring several ends of count into each scenario and reach the degenerate case where a zero reload fires on every cycle. With such short periods, toggling, copying, PWM level changes and watchdog expiry can all be observed over consecutive counts.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_WAIT = 3'd1;
  localparam logic [REG_AW-1:0] A_ISEL = 3'd2;
  localparam logic [REG_AW-1:0] A_RLO  = 3'd3;
  localparam logic [REG_AW-1:0] A_RHI  = 3'd4;
  localparam logic [REG_AW-1:0] A_CMD  = 3'd5;

  typedef struct packed {
    logic in_en;
    logic out_mode;
    logic wr_out;
    logic out_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{in_en: 1'b0, out_mode: 1'b0, wr_out: 1'b1, out_en: 1'b0};
endpackage

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              wdog_en_n,
  output logic              tl_sel,
  output logic              a0_sel,
  output logic [CNT_W-1:0]  reload_val,
  output logic              reload_cmd
);
  localparam int PAD_W = 2 * REG_DW;
  localparam logic [PAD_W-1:0] RLD_PAD_RST = PAD_W'(RELOAD_RST);

  logic [PAD_W-1:0] rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= CTRL_RST;
      wdog_en_n <= 1'b1;
      tl_sel    <= 1'b1;
      a0_sel    <= 1'b1;
      rld_q     <= RLD_PAD_RST;
    end else if (wr) begin
      case (addr)
        A_CTRL: ctrl <= ctrl_t'(wdata[3:0]);
        A_WAIT: wdog_en_n <= wdog_en_n & wdata[6];
        A_ISEL: begin
          tl_sel <= wdata[2];
          a0_sel <= wdata[1];
        end
        A_RLO: rld_q[REG_DW-1:0] <= wdata;
        A_RHI: rld_q[PAD_W-1:REG_DW] <= wdata;
        default: ;
      endcase
    end
  end

  assign reload_val = rld_q[CNT_W-1:0];
  assign reload_cmd = wr && (addr == A_CMD);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {4'b0000, ctrl};
      A_WAIT:  rdata = {1'b0, wdog_en_n, 6'h3F};
      A_ISEL:  rdata = {5'b00000, tl_sel, a0_sel, 1'b0};
      A_RLO:   rdata = rld_q[REG_DW-1:0];
      A_RHI:   rdata = rld_q[PAD_W-1:REG_DW];
      default: rdata = '0;
    endcase
  end

  AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_en_n |=> !wdog_en_n); // R7
endmodule

// File: rtl/tw_counter.sv
module tw_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_cmd,
  output logic             eoc
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= RELOAD_RST;
    else if (reload_cmd || eoc)  cnt_q <= reload_val;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  assign eoc = (cnt_q == '0);

  AST_EOC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> cnt_q == $past(reload_val)); // R2
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_cmd |=> cnt_q == $past(reload_val)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc && !reload_cmd) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
endmodule

// File: rtl/tw_outstage.sv
module tw_outstage
  import tw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eoc,
  input  ctrl_t ctrl,
  output logic  pin,
  output logic  oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pin <= 1'b0;
    else if (eoc && ctrl.out_en)    pin <= ctrl.out_mode ? ctrl.wr_out : ~pin;
  end

  assign oe = ctrl.out_en;

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoc && oe) |=> $stable(pin)); // R6
  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && oe && !ctrl.out_mode) |=> pin != $past(pin)); // R4
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
  import tw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       hw_wdog_strap,
  input  logic       nmi_in,
  input  logic       ext_irq_in,
  output logic       eoc,
  output logic       tmr_pin,
  output logic       tmr_oe,
  output logic       sys_rst_req,
  output logic       tl_irq,
  output logic       a0_irq
);
  ctrl_t            ctrl;
  logic             wdog_en_n, tl_sel, a0_sel, reload_cmd;
  logic [CNT_W-1:0] reload_val;
  logic             wd_mode;

  tw_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl(ctrl), .wdog_en_n(wdog_en_n), .tl_sel(tl_sel),
    .a0_sel(a0_sel), .reload_val(reload_val), .reload_cmd(reload_cmd)
  );

  tw_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val),
    .reload_cmd(reload_cmd), .eoc(eoc)
  );

  tw_outstage u_out (
    .clk(clk), .rst_n(rst_n), .eoc(eoc), .ctrl(ctrl), .pin(tmr_pin), .oe(tmr_oe)
  );

  assign wd_mode     = hw_wdog_strap | ~wdog_en_n;
  assign sys_rst_req = eoc & wd_mode;
  assign tl_irq      = tl_sel ? nmi_in : eoc;
  assign a0_irq      = a0_sel ? ext_irq_in : eoc;

  AST_RST_ONLY_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> eoc); // R8
  AST_STRAP_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wdog_strap && eoc) |-> sys_rst_req); // R9
endmodule

// File: tb/tmr_wdog_tb.sv
module tmr_wdog_tb;
  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic hw_wdog_strap = 1'b0, nmi_in = 1'b0, ext_irq_in = 1'b0;
  logic eoc, tmr_pin, tmr_oe, sys_rst_req, tl_irq, a0_irq;
  int n_run = 0, n_fail = 0;

  tmr_wdog #(.CNT_W(16), .RELOAD_RST(16'd20)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_wdog_strap(hw_wdog_strap),
    .nmi_in(nmi_in), .ext_irq_in(ext_irq_in), .eoc(eoc), .tmr_pin(tmr_pin),
    .tmr_oe(tmr_oe), .sys_rst_req(sys_rst_req), .tl_irq(tl_irq), .a0_irq(a0_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    for (int i = 0; i < WD_LIMIT; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", WD_LIMIT, WD_LIMIT);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_eoc();
    for (int i = 0; i < 200 && !eoc; i++) @(negedge clk);
  endtask

  task automatic set_reload(input logic [15:0] v);
    wr(3'd3, v[7:0]); wr(3'd4, v[15:8]); wr(3'd5, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d); chk(d == 8'h02, "R1 ctrl", d, 8'h02);
    rd(3'd1, d); chk(d == 8'h7F, "R1 wait", d, 8'h7F);
    rd(3'd2, d); chk(d == 8'h06, "R1 isel", d, 8'h06);
    rd(3'd3, d); chk(d == 8'd20, "R1 reload lo", d, 20);
    chk(!tmr_oe && !tmr_pin, "R1 pin/oe", {tmr_oe, tmr_pin}, 0);
  endtask

  task automatic t_period();
    int n;
    wait_eoc();
    n = 0;
    do begin @(negedge clk); n++; end while (!eoc && n < 100);
    chk(n == 21, "R2 default period", n, 21);
    @(negedge clk); chk(!eoc, "R2 single cycle pulse", eoc, 0);
  endtask

  task automatic t_cmd();
    int n;
    set_reload(16'd5);
    n = 0;
    while (!eoc && n < 100) begin @(negedge clk); n++; end
    chk(n == 5, "R3 reload command timing", n, 5);
  endtask

  task automatic t_zero();
    set_reload(16'd0);
    for (int i = 0; i < 3; i++) begin
      chk(eoc, "R2 zero reload every cycle", eoc, 1);
      @(negedge clk);
    end
    set_reload(16'd3);
  endtask

  task automatic t_toggle();
    logic p;
    wr(3'd0, 8'h01);
    chk(tmr_oe, "R4 oe on", tmr_oe, 1);
    for (int k = 0; k < 2; k++) begin
      wait_eoc(); p = tmr_pin; @(negedge clk);
      chk(tmr_pin == ~p, "R4 toggle", tmr_pin, ~p);
    end
  endtask

  task automatic t_copy();
    wr(3'd0, 8'h05);
    wait_eoc(); @(negedge clk);
    chk(tmr_pin == 1'b0, "R5 copy 0", tmr_pin, 0);
    wr(3'd0, 8'h07);
    if (!eoc) chk(tmr_pin == 1'b0, "R5 hold between counts", tmr_pin, 0);
    wait_eoc(); @(negedge clk);
    chk(tmr_pin == 1'b1, "R5 copy 1", tmr_pin, 1);
  endtask

  task automatic t_disabled();
    logic p;
    wr(3'd0, 8'h04);
    chk(!tmr_oe, "R6 oe off", tmr_oe, 0);
    wait_eoc(); p = tmr_pin; @(negedge clk);
    chk(tmr_pin == p, "R6 pin frozen", tmr_pin, p);
  endtask

  task automatic t_strap();
    wait_eoc(); chk(!sys_rst_req, "R8 no request outside watchdog", sys_rst_req, 0);
    hw_wdog_strap = 1'b1; @(negedge clk);
    wait_eoc(); chk(sys_rst_req, "R9 strap forces watchdog", sys_rst_req, 1);
    hw_wdog_strap = 1'b0; @(negedge clk);
    wait_eoc(); chk(!sys_rst_req, "R9 strap released", sys_rst_req, 0);
  endtask

  task automatic t_wdog();
    logic [7:0] d;
    wr(3'd1, 8'h3F);
    rd(3'd1, d); chk(d[6] == 1'b0, "R7 enter watchdog", d, 8'h3F);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk(d[6] == 1'b0, "R7 sticky", d, 8'h3F);
    @(negedge clk);
    if (eoc) @(negedge clk);
    chk(!sys_rst_req, "R8 quiet between counts", sys_rst_req, 0);
    wait_eoc(); chk(sys_rst_req, "R8 request at end of count", sys_rst_req, 1);
  endtask

  task automatic t_mux();
    @(negedge clk); if (eoc) @(negedge clk);
    nmi_in = 1'b1; ext_irq_in = 1'b1; #1;
    chk(tl_irq, "R10 nmi selected", tl_irq, 1);
    chk(a0_irq, "R11 ext selected", a0_irq, 1);
    nmi_in = 1'b0; ext_irq_in = 1'b0; #1;
    chk(!tl_irq && !a0_irq, "R10 R11 follow pins low", {tl_irq, a0_irq}, 0);
    wr(3'd2, 8'h00);
    nmi_in = 1'b1; ext_irq_in = 1'b1;
    if (eoc) @(negedge clk);
    #1; chk(!tl_irq, "R10 eoc selected idle", tl_irq, 0);
    chk(!a0_irq, "R11 eoc selected idle", a0_irq, 0);
    wait_eoc();
    chk(tl_irq, "R10 eoc selected fires", tl_irq, 1);
    chk(a0_irq, "R11 eoc selected fires", a0_irq, 1);
  endtask

  task automatic t_inen();
    logic [7:0] d;
    wr(3'd0, 8'h08);
    rd(3'd0, d); chk(d == 8'h08, "R12 input enable set", d, 8'h08);
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk(d == 8'h00, "R12 input enable clear", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_cmd();
    t_zero();
    t_toggle();
    t_copy();
    t_disabled();
    t_strap();
    t_wdog();
    t_mux();
    t_inen();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule